// File: doc/BRIEF.md
# Amplifier Mode Sequencer

This block orders the power-up and power-down of a two-channel switching audio amplifier. It takes a mode request that has already been digitized from a threshold comparator and debounced: standby, mute or operate. From this request it drives four enables in a fixed order. A short-to-supply test of the outputs runs first. The power stage is then enabled, PWM switching starts, and last the audio is released.

All delays are counted in ticks of a 1 kHz strobe. The first delay sets the earliest start of switching, 110 ms by default. The second delay sets the earliest audio release after the mode request, 220 ms by default. The start-up test is only requested while the sequence waits to enable the stage, so it never disturbs a running amplifier. A fault flag from the protection logic turns everything off. When the flag clears, the timed start-up runs again. A standby request drops every enable on the next clock.

Top module: `amp_mode_seq`

## Requirements
- R1: During and right after the synchronous active-high reset, all four outputs are low and the sequencer is in standby.
- R2: `mode_req` encoding is 0 = standby, 1 = mute, 2 = operate. Code 3 is reserved and behaves exactly like standby.
- R3: From standby, a mute or operate request (with no fault) raises `short_test_req` on the next clock. Switching begins only after `T_SHORT` ticks have been counted since the request.
- R4: `pwr_stage_en` is never raised while `short_test_ok` is low. The sequencer waits with the stage off and the test request high for as long as the test fails.
- R5: `pwr_stage_en` rises on the clock after the test passes, and `short_test_req` falls at the same moment. `pwm_run` follows exactly one clock later. `short_test_req` is never high together with `pwr_stage_en`.
- R6: `audio_on` rises only while operate is requested. It also needs at least `T_LONG - T_SHORT` ticks counted since switching began or since the last mode change.
- R7: A mute request while audio is on drops `audio_on` on the next clock and keeps `pwm_run` and `pwr_stage_en` high.
- R8: A standby request (code 0 or 3) drops all four outputs on the next clock, from any state.
- R9: While `prot_fault` is high, all outputs are low from the next clock on. When it clears, the start-up sequence, test included, restarts from its beginning.
- R10: The tick counter restarts whenever the requested mode changes, so a mode change during a delay restarts that delay.
- R11: `audio_on` implies `pwm_run`, and `pwm_run` implies `pwr_stage_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-clock strobe at 1 kHz |
| mode_req | input | 2 | Requested mode (0 standby, 1 mute, 2 operate, 3 as standby) |
| short_test_ok | input | 1 | Output short test passes |
| prot_fault | input | 1 | Global fault from the protection logic |
| pwr_stage_en | output | 1 | Power stage enable |
| pwm_run | output | 1 | PWM switching enable |
| audio_on | output | 1 | Audio released (unmute) |
| short_test_req | output | 1 | Request to run the output short test |

## Verification
The bench builds the block with `T_SHORT = 4` and `T_LONG = 10`. It drives `tick_ms` directly, one pulse at a time. This puts every delay boundary a few pulses away, so each can be probed one tick before and one tick after it fires. The small gap of six ticks also makes the mute-to-operate and fault-recovery paths short enough to run several times. The counter's saturation and restart can then be exercised with counts that would change the outcome.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

    typedef enum logic [1:0] {
        REQ_STBY = 2'd0,
        REQ_MUTE = 2'd1,
        REQ_OPER = 2'd2,
        REQ_RSVD = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        SQ_STBY = 3'd0,
        SQ_TEST = 3'd1,
        SQ_ARM  = 3'd2,
        SQ_RUN  = 3'd3,
        SQ_PLAY = 3'd4,
        SQ_HOLD = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic stage;
        logic pwm;
        logic audio;
        logic test;
    } seq_out_t;

    function automatic logic is_standby(req_e r);
        return (r == REQ_STBY) || (r == REQ_RSVD);
    endfunction

    function automatic seq_out_t decode_state(seq_state_e s);
        seq_out_t o;
        o.test  = (s == SQ_TEST);
        o.stage = (s == SQ_ARM) || (s == SQ_RUN) || (s == SQ_PLAY);
        o.pwm   = (s == SQ_RUN) || (s == SQ_PLAY);
        o.audio = (s == SQ_PLAY);
        return o;
    endfunction

endpackage

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
    parameter int unsigned CNT_MAX = 220,
    parameter int unsigned CW      = $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] SAT = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (tick && (cnt_q != SAT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/amp_seq_fsm.sv
module amp_seq_fsm
    import amp_seq_pkg::*;
#(
    parameter int unsigned CW      = 8,
    parameter int unsigned T_START = 110,
    parameter int unsigned T_GAP   = 110
) (
    input  logic          clk,
    input  logic          rst,
    input  req_e          mode,
    input  logic [CW-1:0] cnt,
    input  logic          test_ok,
    input  logic          fault,
    output seq_state_e    state,
    output logic          restart
);
    localparam logic [CW-1:0] START_C = CW'(T_START);
    localparam logic [CW-1:0] GAP_C   = CW'(T_GAP);

    seq_state_e state_q, state_d;
    req_e       mode_q;

    always_comb begin
        state_d = state_q;
        if (is_standby(mode)) begin
            state_d = SQ_STBY;
        end else if (state_q == SQ_STBY) begin
            if (!fault) state_d = SQ_TEST;
        end else if (fault) begin
            state_d = SQ_HOLD;
        end else begin
            unique case (state_q)
                SQ_TEST: if ((cnt >= START_C) && test_ok) state_d = SQ_ARM;
                SQ_ARM:  state_d = SQ_RUN;
                SQ_RUN:  if ((mode == REQ_OPER) && (cnt >= GAP_C)) state_d = SQ_PLAY;
                SQ_PLAY: if (mode == REQ_MUTE) state_d = SQ_RUN;
                SQ_HOLD: state_d = SQ_TEST;
                default: state_d = SQ_STBY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_STBY;
            mode_q  <= REQ_STBY;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    assign state   = state_q;
    assign restart = (state_d != state_q) || (mode != mode_q);
endmodule

// File: rtl/amp_seq_outdec.sv
module amp_seq_outdec
    import amp_seq_pkg::*;
(
    input  seq_state_e state,
    output seq_out_t   outs
);
    always_comb outs = decode_state(state);
endmodule

// File: rtl/amp_mode_seq.sv
module amp_mode_seq
    import amp_seq_pkg::*;
#(
    parameter int unsigned T_SHORT = 110,
    parameter int unsigned T_LONG  = 220
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms,
    input  logic [1:0] mode_req,
    input  logic       short_test_ok,
    input  logic       prot_fault,
    output logic       pwr_stage_en,
    output logic       pwm_run,
    output logic       audio_on,
    output logic       short_test_req
);
    localparam int unsigned T_GAP = T_LONG - T_SHORT;
    localparam int unsigned CW    = $clog2(T_LONG + 1);

    logic [CW-1:0] cnt;
    logic          restart;
    seq_state_e    state;
    seq_out_t      outs;

    amp_seq_timer #(.CNT_MAX(T_LONG), .CW(CW)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .tick (tick_ms),
        .cnt  (cnt)
    );

    amp_seq_fsm #(.CW(CW), .T_START(T_SHORT), .T_GAP(T_GAP)) i_fsm (
        .clk     (clk),
        .rst     (rst),
        .mode    (req_e'(mode_req)),
        .cnt     (cnt),
        .test_ok (short_test_ok),
        .fault   (prot_fault),
        .state   (state),
        .restart (restart)
    );

    amp_seq_outdec i_dec (
        .state (state),
        .outs  (outs)
    );

    assign pwr_stage_en   = outs.stage;
    assign pwm_run        = outs.pwm;
    assign audio_on       = outs.audio;
    assign short_test_req = outs.test;
endmodule

// File: rtl/amp_mode_seq_chk.sv
module amp_mode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_req,
    input logic       short_test_ok,
    input logic       prot_fault,
    input logic       pwr_stage_en,
    input logic       pwm_run,
    input logic       audio_on,
    input logic       short_test_req
);
    // R11
    audio_needs_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        audio_on |-> pwm_run);

    // R11
    pwm_needs_stage_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_run |-> pwr_stage_en);

    // R5
    test_excl_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !(short_test_req && pwr_stage_en));

    // R5
    stage_before_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_run) |-> $past(pwr_stage_en));

    // R4
    stage_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_stage_en) |-> $past(short_test_ok));

    // R6
    audio_needs_oper_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(audio_on) |-> ($past(mode_req) == 2'd2));

    // R8
    standby_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_req == 2'd0 || mode_req == 2'd3) |=>
            !(pwr_stage_en || pwm_run || audio_on || short_test_req));

    // R9
    fault_off_chk: assert property (@(posedge clk) disable iff (rst)
        prot_fault |=> !(pwr_stage_en || pwm_run || audio_on));
endmodule

bind amp_mode_seq amp_mode_seq_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_req       (mode_req),
    .short_test_ok  (short_test_ok),
    .prot_fault     (prot_fault),
    .pwr_stage_en   (pwr_stage_en),
    .pwm_run        (pwm_run),
    .audio_on       (audio_on),
    .short_test_req (short_test_req)
);

// File: tb/test_amp_mode_seq.sv
`timescale 1ns/1ps
module test_amp_mode_seq;
    localparam int S = 4;
    localparam int L = 10;
    localparam int G = L - S;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0;
    logic [1:0] mode_req = 2'd0;
    logic short_test_ok = 1'b1;
    logic prot_fault = 1'b0;
    logic pwr_stage_en, pwm_run, audio_on, short_test_req;

    int n_run = 0;
    int n_fail = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    amp_mode_seq #(.T_SHORT(S), .T_LONG(L)) i_amp_mode_seq (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .mode_req(mode_req),
        .short_test_ok(short_test_ok), .prot_fault(prot_fault),
        .pwr_stage_en(pwr_stage_en), .pwm_run(pwm_run),
        .audio_on(audio_on), .short_test_req(short_test_req)
    );

    // Behavioural reference: 0 standby, 1 test, 2 arm, 3 run, 4 play, 5 hold
    int m_st = 0, m_cnt = 0, m_pm = 0;
    always @(posedge clk) begin
        int m, nst;
        bit sb, clr;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_pm = 0;
        end else begin
            m = int'(mode_req);
            sb = (m == 0) || (m == 3);
            nst = m_st;
            if (sb) nst = 0;
            else if (m_st == 0) nst = prot_fault ? 0 : 1;
            else if (prot_fault) nst = 5;
            else if (m_st == 1) begin if (m_cnt >= S && short_test_ok) nst = 2; end
            else if (m_st == 2) nst = 3;
            else if (m_st == 3) begin if (m == 2 && m_cnt >= G) nst = 4; end
            else if (m_st == 4) begin if (m == 1) nst = 3; end
            else nst = 1;
            clr = (nst != m_st) || (m != m_pm);
            if (clr) m_cnt = 0;
            else if (tick_ms && m_cnt < L) m_cnt = m_cnt + 1;
            m_pm = m;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        logic [3:0] e, a;
        if (!rst) begin
            e = {m_st >= 2 && m_st <= 4, m_st == 3 || m_st == 4, m_st == 4, m_st == 1};
            a = {pwr_stage_en, pwm_run, audio_on, short_test_req};
            n_run++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s model compare: {stage,pwm,audio,test} actual=%b expected=%b",
                         cur_req, a, e);
            end
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_req = m;
        step(1);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1; step(1);
            tick_ms = 1'b0; step(2);
        end
    endtask

    task automatic all_off(string req);
        check(req, "stage", pwr_stage_en, 1'b0);
        check(req, "pwm", pwm_run, 1'b0);
        check(req, "audio", audio_on, 1'b0);
        check(req, "test", short_test_req, 1'b0);
    endtask

    initial begin
        step(1);
        all_off("R1");
        step(2);
        rst = 1'b0;
        step(1);
        all_off("R1");

        // mute path
        cur_req = "R3";
        set_mode(2'd1);
        check("R3", "test request after mute", short_test_req, 1'b1);
        pulses(S - 1);
        check("R3", "pwm one tick early", pwm_run, 1'b0);
        pulses(1);
        check("R3", "pwm after short delay", pwm_run, 1'b1);
        cur_req = "R6";
        pulses(G);
        check("R6", "audio held in mute", audio_on, 1'b0);
        set_mode(2'd2);
        check("R6", "audio on operate after gap", audio_on, 1'b1);

        // direct operate from standby
        cur_req = "R8";
        set_mode(2'd0);
        all_off("R8");
        cur_req = "R6";
        set_mode(2'd2);
        pulses(S);
        check("R6", "pwm after start", pwm_run, 1'b1);
        pulses(G - 1);
        check("R6", "audio one tick early", audio_on, 1'b0);
        pulses(1);
        check("R6", "audio after gap", audio_on, 1'b1);

        // back to mute
        cur_req = "R7";
        set_mode(2'd1);
        check("R7", "audio drops", audio_on, 1'b0);
        check("R7", "pwm kept", pwm_run, 1'b1);
        set_mode(2'd2);
        pulses(G);
        check("R7", "audio back after gap", audio_on, 1'b1);

        cur_req = "R8";
        set_mode(2'd0);
        all_off("R8");

        // failing start-up test
        cur_req = "R4";
        short_test_ok = 1'b0;
        set_mode(2'd1);
        pulses(S + 3);
        check("R4", "stage off while test fails", pwr_stage_en, 1'b0);
        check("R4", "test still requested", short_test_req, 1'b1);
        cur_req = "R5";
        short_test_ok = 1'b1;
        step(1);
        check("R5", "stage on after pass", pwr_stage_en, 1'b1);
        check("R5", "pwm not yet", pwm_run, 1'b0);
        check("R5", "test dropped", short_test_req, 1'b0);
        step(1);
        check("R5", "pwm one clock later", pwm_run, 1'b1);

        // fault
        cur_req = "R9";
        prot_fault = 1'b1;
        step(1);
        all_off("R9");
        pulses(3);
        check("R9", "stage off during fault", pwr_stage_en, 1'b0);
        prot_fault = 1'b0;
        step(1);
        check("R9", "test restarts", short_test_req, 1'b1);
        pulses(S - 1);
        check("R9", "pwm waits full delay", pwm_run, 1'b0);
        pulses(1);
        check("R9", "pwm after restart", pwm_run, 1'b1);

        // reserved code
        cur_req = "R2";
        set_mode(2'd3);
        all_off("R2");
        pulses(S);
        check("R2", "reserved stays off", pwr_stage_en, 1'b0);

        // counter restart on mode change
        cur_req = "R10";
        set_mode(2'd2);
        pulses(S - 2);
        set_mode(2'd1);
        pulses(S - 1);
        check("R10", "delay restarted", pwm_run, 1'b0);
        pulses(1);
        check("R10", "pwm after restarted delay", pwm_run, 1'b1);
        check("R11", "stage with pwm", pwr_stage_en, 1'b1);

        step(3);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule